// File: doc/BRIEF.md
# Fractional MAC Result Extractor

This block turns the contents of a 48-bit multiply-accumulate accumulator into a 32-bit register value. One request carries a 64-bit operand, a 2-bit extraction kind and three mode bits. The mode bits are a half-width select, a rounding enable and a saturation enable. There are four extraction kinds:

- fractional extraction, with round-half-to-even and optional clamping;
- signed integer extraction, which clamps on overflow;
- unsigned integer extraction, which clamps on overflow;
- a product scaling path, which takes a raw 64-bit fractional product down by 24 bits, with rounding as an option.

For the three accumulator kinds, the accumulator value is operand bits 47:0, read as a two's complement number. The scaling kind uses all 64 operand bits as an unsigned product.

The result is captured in a register. It appears one clock after the request, with a valid flag. The multiplier array and the accumulator register file sit outside this block.

Top module: `mac_result_extract`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is 0 and `res_data` is 0.
- R2: A request with `req_valid` high at a rising edge shows its result on `res_data`, with `res_valid` high, after that same edge. After an edge with no request, `res_valid` is 0 and `res_data` keeps its last value.
- R3: Kind 0 (fractional) with `mode_half`=1 works as follows. The candidate is accumulator bits 47:24, signed, and the remainder is bits 23:0. Rounding is always applied: add 1 if the remainder is above 0x800000, and add the candidate's bit 0 if it equals 0x800000. The result goes in bits 15:0, and bits 31:16 are 0.
- R4: In that half-width mode with `mode_sat`=1, a rounded candidate outside the signed 16-bit range gives 0x7FFF when positive and 0x8000 when negative. With `mode_sat`=0, the low 16 bits are kept.
- R5: Kind 0 with `mode_half`=0 and `mode_round`=1 works as follows. The candidate is accumulator bits 47:8, signed, and the remainder is bits 7:0. Add 1 if the remainder is above 0x80, and add the candidate's bit 0 if it equals 0x80.
- R6: Kind 0 with `mode_half`=0 and `mode_round`=0 truncates: the result is the candidate with no increment.
- R7: In that full-width fractional mode with `mode_sat`=1, a candidate outside the signed 32-bit range gives 0x7FFFFFFF when positive and 0x80000000 when negative. With `mode_sat`=0, the low 32 bits are kept.
- R8: Kind 1 (signed integer) returns the low 32 bits when the accumulator fits a signed 32-bit number. Otherwise it returns 0x7FFFFFFF if bit 47 is 0 and 0x80000000 if bit 47 is 1. The mode bits have no effect.
- R9: Kind 2 (unsigned integer) returns the low 32 bits when accumulator bits 47:32 are all zero. Otherwise it returns 0xFFFFFFFF.
- R10: Kind 3 (product scale) shifts the 64-bit operand right by 24. When `mode_round`=1 it applies the same above/equal 0x800000 ties-to-even increment to the discarded 24 bits. The result is the low 32 bits.
- R11: For kinds 0, 1 and 2, operand bits 63:48 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 fractional, 1 signed int, 2 unsigned int, 3 product scale |
| mode_half | input | 1 | 1 selects 16-bit fractional result |
| mode_round | input | 1 | Rounding enable (full-width fractional and scale) |
| mode_sat | input | 1 | Saturation enable (fractional kinds) |
| req_operand | input | 64 | Accumulator in bits 47:0, or full product |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_data | output | 32 | Registered result |

## Verification
Every result is due one register stage after its request. The bench drives each request on a falling edge and removes it on the next falling edge. It then samples `res_valid` and `res_data` at that point, which is after exactly one rising edge. To check the hold and idle behaviour, the bench waits one more full cycle with no request and samples again at the falling edge. The rounding tie and overflow corners are each placed as the only request in flight, so every value sampled belongs to one known request.

// File: rtl/mac_ext_pkg.sv
// Shared sizes and the extraction-kind encoding for the result extractor.
// Assumes a 48-bit accumulator and a 64-bit raw product.
package mac_ext_pkg;
    localparam int ACC_W     = 48;   // accumulator width
    localparam int OPD_W     = 64;   // request operand width
    localparam int RES_W     = 32;   // register result width
    localparam int HALF_W    = 16;   // half-width fractional result
    localparam int WIDE_SH   = 24;   // discarded bits, half mode and scaling
    localparam int NARROW_SH = 8;    // discarded bits, full-width fractional

    typedef enum logic [1:0] {
        KIND_FRAC  = 2'd0,
        KIND_SINT  = 2'd1,
        KIND_UINT  = 2'd2,
        KIND_SCALE = 2'd3
    } ext_kind_e;
endpackage

// File: rtl/rne_round.sv
// Round-half-to-even increment of a shifted candidate.
// Assumes the remainder holds the discarded bits, with RW >= 2.
// EXT=1 widens the sum by one bit (sign or zero, per SIGNED) so that the
// carry out of the increment is kept.
module rne_round #(
    parameter int CW     = 40,
    parameter int RW     = 8,
    parameter int EXT    = 1,
    parameter int SIGNED = 1
) (
    input  logic [CW-1:0]     cand,
    input  logic [RW-1:0]     rem,
    input  logic              en,
    output logic [CW+EXT-1:0] sum
);
    localparam int OW = CW + EXT;

    logic          inc;
    logic [OW-1:0] base;

    // Increment above half, or on exactly half when the candidate is odd.
    always_comb begin
        inc = en & rem[RW-1] & ((|rem[RW-2:0]) | cand[0]);
    end

    generate
        if (EXT != 0) begin : g_wide
            assign base = {((SIGNED != 0) & cand[CW-1]), cand};
        end else begin : g_same
            assign base = cand;
        end
    endgenerate

    // Apply the increment.
    always_comb begin
        sum = base + OW'(inc);
    end
endmodule

// File: rtl/sat_clamp.sv
// Narrows a signed value to OW bits. When en is set and the value does not
// fit, it clamps to the largest or smallest OW-bit value by sign.
// Assumes IW > OW.
module sat_clamp #(
    parameter int IW = 41,
    parameter int OW = 32
) (
    input  logic [IW-1:0] val,
    input  logic          en,
    output logic [OW-1:0] out
);
    logic fits;

    // The value fits when every bit from OW-1 upward matches the sign.
    always_comb begin
        fits = (&val[IW-1:OW-1]) | ~(|val[IW-1:OW-1]);
    end

    // Pick the clamp value or the plain truncation.
    always_comb begin
        if (en && !fits) begin
            out = val[IW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
        end else begin
            out = val[OW-1:0];
        end
    end

    // The clamped result keeps the sign of the input.
    always_comb begin
        if (en) begin
            assert (out[OW-1] == val[IW-1] || fits) else $error("AST_CLAMP_SIGN"); // R7
        end
    end
endmodule

// File: rtl/mac_result_extract.sv
// Converts an accumulator value or a raw product into a 32-bit register result.
// The result is registered one cycle after a qualified request. The mode bits
// and the kind are sampled together with the request.
// Assumes the accumulator occupies operand bits 47:0 in two's complement.
module mac_result_extract
    import mac_ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              mode_half,
    input  logic              mode_round,
    input  logic              mode_sat,
    input  logic [OPD_W-1:0]  req_operand,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data
);
    localparam int HCAND_W = ACC_W - WIDE_SH;     // 24-bit half-mode candidate
    localparam int FCAND_W = ACC_W - NARROW_SH;   // 40-bit full-mode candidate
    localparam int SCAND_W = OPD_W - WIDE_SH;     // 40-bit scaled product

    logic [ACC_W-1:0]   acc;
    ext_kind_e          kind;
    logic [HCAND_W:0]   half_rnd;
    logic [HALF_W-1:0]  half_val;
    logic [FCAND_W:0]   full_rnd;
    logic [RES_W-1:0]   full_val;
    logic [RES_W-1:0]   sint_val;
    logic [RES_W-1:0]   uint_val;
    logic [SCAND_W-1:0] scale_rnd;
    logic [RES_W-1:0]   next_data;

    // Split the request into the accumulator view and the kind.
    always_comb begin
        acc  = req_operand[ACC_W-1:0];
        kind = ext_kind_e'(req_kind);
    end

    // Half-width fractional: always rounded, with optional clamp.
    rne_round #(.CW(HCAND_W), .RW(WIDE_SH), .EXT(1), .SIGNED(1)) u_half_rnd (
        .cand (acc[ACC_W-1:WIDE_SH]),
        .rem  (acc[WIDE_SH-1:0]),
        .en   (1'b1),
        .sum  (half_rnd)
    );
    sat_clamp #(.IW(HCAND_W + 1), .OW(HALF_W)) u_half_sat (
        .val (half_rnd),
        .en  (mode_sat),
        .out (half_val)
    );

    // Full-width fractional: optional rounding, then optional clamp.
    rne_round #(.CW(FCAND_W), .RW(NARROW_SH), .EXT(1), .SIGNED(1)) u_full_rnd (
        .cand (acc[ACC_W-1:NARROW_SH]),
        .rem  (acc[NARROW_SH-1:0]),
        .en   (mode_round),
        .sum  (full_rnd)
    );
    sat_clamp #(.IW(FCAND_W + 1), .OW(RES_W)) u_full_sat (
        .val (full_rnd),
        .en  (mode_sat),
        .out (full_val)
    );

    // Signed integer: the clamp is always on.
    sat_clamp #(.IW(ACC_W), .OW(RES_W)) u_sint_sat (
        .val (acc),
        .en  (1'b1),
        .out (sint_val)
    );

    // Unsigned integer: all ones when any upper accumulator bit is set.
    always_comb begin
        uint_val = (|acc[ACC_W-1:RES_W]) ? {RES_W{1'b1}} : acc[RES_W-1:0];
    end

    // Product scaling: drop 24 bits, rounding as an option, keep the low word.
    rne_round #(.CW(SCAND_W), .RW(WIDE_SH), .EXT(0), .SIGNED(0)) u_scale_rnd (
        .cand (req_operand[OPD_W-1:WIDE_SH]),
        .rem  (req_operand[WIDE_SH-1:0]),
        .en   (mode_round),
        .sum  (scale_rnd)
    );

    // Select the result for the requested kind.
    always_comb begin
        unique case (kind)
            KIND_FRAC:  next_data = mode_half ? {{(RES_W-HALF_W){1'b0}}, half_val}
                                              : full_val;
            KIND_SINT:  next_data = sint_val;
            KIND_UINT:  next_data = uint_val;
            default:    next_data = RES_W'(scale_rnd);
        endcase
    end

    // Output register: capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_data <= next_data;
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(res_data))); // R2
    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0 && mode_half) |=> (res_data[31:16] == 16'h0)); // R3
    AST_UINT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2 && (|req_operand[47:32])) |=> (res_data == 32'hFFFF_FFFF)); // R9
    AST_SINT_POS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1 && !req_operand[47] && (|req_operand[46:31]))
        |=> (res_data == 32'h7FFF_FFFF)); // R8
    AST_SINT_NEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1 && req_operand[47] && !(&req_operand[46:31]))
        |=> (res_data == 32'h8000_0000)); // R8
endmodule

// File: tb/mac_result_extract_test.sv
`timescale 1ns/1ps
module mac_result_extract_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        mode_half = 1'b0;
    logic        mode_round = 1'b0;
    logic        mode_sat = 1'b0;
    logic [63:0] req_operand = 64'h0;
    logic        res_valid;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mac_result_extract uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .mode_half(mode_half), .mode_round(mode_round), .mode_sat(mode_sat),
        .req_operand(req_operand), .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request, sampled after exactly one rising edge.
    task automatic run(input string tag, input logic [1:0] k, input logic h,
                       input logic r, input logic s, input logic [63:0] op,
                       input logic [31:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; mode_half = h; mode_round = r;
        mode_sat = s; req_operand = op;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {31'h0, res_valid}, 32'h1);
        check(tag, res_data, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'h0, res_valid}, 32'h0);
        check("R1 data", res_data, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_timing();
        logic [31:0] held;
        run("R2 req", 2'd2, 1'b0, 1'b0, 1'b0, 64'h0000_0000_CAFE_F00D, 32'hCAFE_F00D);
        held = res_data;
        req_operand = 64'h0000_0000_0000_0001;
        @(negedge clk);
        check("R2 idle valid", {31'h0, res_valid}, 32'h0);
        check("R2 idle hold", res_data, held);
    endtask

    task automatic t_half();
        run("R3 tie even",  2'd0, 1, 0, 0, 64'h0000_0012_3480_0000, 32'h0000_1234);
        run("R3 tie odd",   2'd0, 1, 0, 0, 64'h0000_0012_3580_0000, 32'h0000_1236);
        run("R3 above",     2'd0, 1, 0, 0, 64'h0000_0012_3480_0001, 32'h0000_1235);
        run("R3 below",     2'd0, 1, 0, 0, 64'h0000_0012_347F_FFFF, 32'h0000_1234);
        run("R3 negative",  2'd0, 1, 0, 0, 64'h0000_FFFF_FE00_0000, 32'h0000_FFFE);
        run("R4 pos sat",   2'd0, 1, 0, 1, 64'h0000_0123_4500_0000, 32'h0000_7FFF);
        run("R4 pos wrap",  2'd0, 1, 0, 0, 64'h0000_0123_4500_0000, 32'h0000_2345);
        run("R4 neg sat",   2'd0, 1, 0, 1, 64'h0000_F000_0000_0000, 32'h0000_8000);
        run("R4 neg wrap",  2'd0, 1, 0, 0, 64'h0000_F000_0000_0000, 32'h0000_0000);
        run("R4 round ovf", 2'd0, 1, 0, 1, 64'h0000_007F_FFFF_FFFF, 32'h0000_7FFF);
    endtask

    task automatic t_full();
        run("R5 tie even",  2'd0, 0, 1, 0, 64'h0000_0000_1234_5680, 32'h0012_3456);
        run("R5 tie odd",   2'd0, 0, 1, 0, 64'h0000_0000_1234_5780, 32'h0012_3458);
        run("R5 above",     2'd0, 0, 1, 0, 64'h0000_0000_1234_5681, 32'h0012_3457);
        run("R5 neg tie",   2'd0, 0, 1, 0, 64'h0000_FFFF_FFFF_FF80, 32'h0000_0000);
        run("R6 truncate",  2'd0, 0, 0, 0, 64'h0000_0000_1234_56FF, 32'h0012_3456);
        run("R5 round up",  2'd0, 0, 1, 0, 64'h0000_0000_1234_56FF, 32'h0012_3457);
        run("R7 pos sat",   2'd0, 0, 0, 1, 64'h0000_0100_0000_0000, 32'h7FFF_FFFF);
        run("R7 pos wrap",  2'd0, 0, 0, 0, 64'h0000_0100_0000_0000, 32'h0000_0000);
        run("R7 neg sat",   2'd0, 0, 0, 1, 64'h0000_8000_0000_0000, 32'h8000_0000);
        run("R7 round ovf", 2'd0, 0, 1, 1, 64'h0000_007F_FFFF_FFFF, 32'h7FFF_FFFF);
        run("R7 ovf wrap",  2'd0, 0, 1, 0, 64'h0000_007F_FFFF_FFFF, 32'h8000_0000);
    endtask

    task automatic t_int();
        run("R8 max fit",   2'd1, 0, 0, 0, 64'h0000_0000_7FFF_FFFF, 32'h7FFF_FFFF);
        run("R8 pos clamp", 2'd1, 0, 0, 0, 64'h0000_0000_8000_0000, 32'h7FFF_FFFF);
        run("R8 min fit",   2'd1, 0, 0, 0, 64'h0000_FFFF_8000_0000, 32'h8000_0000);
        run("R8 neg clamp", 2'd1, 1, 1, 1, 64'h0000_FFFF_7FFF_FFFF, 32'h8000_0000);
        run("R8 modes",     2'd1, 1, 1, 1, 64'h0000_FFFF_FFFF_FFFE, 32'hFFFF_FFFE);
        run("R9 fits",      2'd2, 0, 0, 0, 64'h0000_0000_DEAD_BEEF, 32'hDEAD_BEEF);
        run("R9 bit32",     2'd2, 0, 0, 0, 64'h0000_0001_0000_0000, 32'hFFFF_FFFF);
        run("R9 bit47",     2'd2, 0, 0, 0, 64'h0000_8000_0000_0001, 32'hFFFF_FFFF);
    endtask

    task automatic t_scale();
        run("R10 tie even", 2'd3, 0, 1, 0, 64'h0000_0012_3480_0000, 32'h0000_1234);
        run("R10 tie odd",  2'd3, 0, 1, 0, 64'h0000_0012_3580_0000, 32'h0000_1236);
        run("R10 no round", 2'd3, 0, 0, 0, 64'h0000_0012_3580_0000, 32'h0000_1235);
        run("R10 wide",     2'd3, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, 32'h3456_789A);
        run("R10 wide rnd", 2'd3, 0, 1, 0, 64'h1234_5678_9ABC_DEF0, 32'h3456_789B);
        run("R10 all ones", 2'd3, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0000);
        run("R10 ones trunc", 2'd3, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_upper_ignored();
        run("R11 frac",  2'd0, 1, 0, 0, 64'hFFFF_0012_3480_0000, 32'h0000_1234);
        run("R11 uint",  2'd2, 0, 0, 0, 64'hABCD_0000_DEAD_BEEF, 32'hDEAD_BEEF);
        run("R11 sint",  2'd1, 0, 0, 0, 64'h8000_0000_0000_0005, 32'h0000_0005);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_half();
        t_full();
        t_int();
        t_scale();
        t_upper_ignored();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule